// File: doc/BRIEF.md
# Two-Block BLAKE2s Hasher for 80-Byte Headers

This block produces the 256-bit BLAKE2s digest of a message that is always exactly 80 bytes long and carries no key. The caller presents the whole message at once as twenty 32-bit words and pulses a start strobe. The core captures the words and runs two compressions on one shared datapath. The first compression takes message words 0 to 15. The second takes words 16 to 19, with zeros in the remaining twelve slots. When both are finished the core raises a single-cycle done strobe and presents the eight digest words.

The datapath evaluates four G functions in parallel, which is one column step or one diagonal step, every clock. One round therefore takes two cycles and one compression takes twenty. The byte counters and the last-block flag are constants, so the core has no general length logic.

Top module: `b2s_hdr_hash`

## Requirements
- R1: While rst_ni is low, and after it is released until the first accepted start, busy_o and done_o are 0 and digest_o is all zeros.
- R2: When start_i is high at a rising edge and the core is idle (busy_o low), msg_i is captured and busy_o is high from the next cycle on. A start presented in the same cycle that done_o is high is accepted.
- R3: done_o is high for exactly one cycle, 40 rising edges after the edge that accepted the start. busy_o falls at that same edge.
- R4: While busy_o is high, start_i and any change on msg_i have no effect on the timing or on the resulting digest.
- R5: digest_o changes only at the edge that raises done_o, and it keeps its value until the next completed hash.
- R6: digest_o equals BLAKE2s-256 of the 80-byte message. Message word k is msg_i[32k+31:32k] and holds bytes 4k..4k+3 little-endian. Digest word k is digest_o[32k+31:32k] in the same byte order.
- R7: The chaining value starts from the eight standard BLAKE2s IV words, with word 0 XORed with 0x01010020. Each compression XORs v[12] with its byte count: 64 for the first block and 80 for the second. Only the second compression inverts v[14]. The second block uses message words 16 to 19 followed by twelve zero words. After each block, h[i] becomes h[i] ^ v[i] ^ v[i+8].
- R8: Each compression runs 10 rounds. Each round applies G first to the four columns and then to the four diagonals. G uses rotations of 16, 12, 8 and 7 and additions modulo 2^32. G index i of round r takes message words sigma[r][2i] and sigma[r][2i+1] from the standard ten-row permutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only while idle |
| msg_i | input | 640 | Twenty message words, word k at bits 32k+31:32k |
| busy_o | output | 1 | Hash in progress |
| done_o | output | 1 | One-cycle completion strobe |
| digest_o | output | 256 | Eight digest words, word k at bits 32k+31:32k |

## Verification
The bench builds the core with its default of ten rounds, so every digest it produces is a true BLAKE2s-256 value. Before the model is used against the core, it is checked against the published digest of the empty message. The core's busy, done and digest outputs are compared with a cycle-accurate behavioural model on every clock. The stimulus covers an all-zero message, random messages, a start request and message changes during a hash, and a start held high so that hashes run back to back and the restart lands in the done cycle.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
  typedef logic [31:0] word_t;

  localparam int MSG_WORDS = 20;
  localparam int DIG_WORDS = 8;
  localparam word_t PARAM_WORD = 32'h0101_0020;

  localparam word_t IV [8] = '{
    32'h6A09E667, 32'hBB67AE85, 32'h3C6EF372, 32'hA54FF53A,
    32'h510E527F, 32'h9B05688C, 32'h1F83D9AB, 32'h5BE0CD19
  };

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // permutation rows packed as 16 nibbles, first entry in the top nibble
  function automatic logic [3:0] sigma_idx(logic [3:0] row, int k);
    logic [63:0] r;
    case (row)
      4'd1:    r = 64'hEA489FD61C02B753;
      4'd2:    r = 64'hB8C052FDAE367194;
      4'd3:    r = 64'h7931DCBE265A40F8;
      4'd4:    r = 64'h905724AFE1BC683D;
      4'd5:    r = 64'h2C6A0B834D75FE19;
      4'd6:    r = 64'hC51FED4A0763928B;
      4'd7:    r = 64'hDB7EC13950F4862A;
      4'd8:    r = 64'h6FE9B308C2D714A5;
      4'd9:    r = 64'hA2847615FB9E3CD0;
      default: r = 64'h0123456789ABCDEF;
    endcase
    return r[63 - 4*k -: 4];
  endfunction
endpackage

// File: rtl/b2s_g.sv
module b2s_g
  import b2s_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  input  word_t x_i,
  input  word_t y_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;

  always_comb begin
    a1  = a_i + b_i + x_i;
    d1  = rotr(d_i ^ a1, 16);
    c1  = c_i + d1;
    b1  = rotr(b_i ^ c1, 12);
    a_o = a1 + b1 + y_i;
    d_o = rotr(d1 ^ a_o, 8);
    c_o = c1 + d_o;
    b_o = rotr(b1 ^ c_o, 7);
  end
endmodule

// File: rtl/b2s_half.sv
// one column step (diag_i=0) or diagonal step (diag_i=1): four G lanes
module b2s_half
  import b2s_pkg::*;
#(
  parameter int LANES = 4
) (
  input  word_t      v_i [16],
  input  word_t      m_i [16],
  input  logic [3:0] row_i,
  input  logic       diag_i,
  output word_t      v_o [16]
);
  logic [3:0] ia [LANES], ib [LANES], ic [LANES], id [LANES];
  word_t ga [LANES], gb [LANES], gc [LANES], gd [LANES], gx [LANES], gy [LANES];
  word_t oa [LANES], ob [LANES], oc [LANES], od [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      int sh, gi;
      sh = diag_i ? 1 : 0;
      gi = diag_i ? LANES + i : i;
      ia[i] = 4'(i);
      ib[i] = 4'(4  + ((i + sh) % 4));
      ic[i] = 4'(8  + ((i + 2*sh) % 4));
      id[i] = 4'(12 + ((i + 3*sh) % 4));
      ga[i] = v_i[ia[i]];
      gb[i] = v_i[ib[i]];
      gc[i] = v_i[ic[i]];
      gd[i] = v_i[id[i]];
      gx[i] = m_i[sigma_idx(row_i, 2*gi)];
      gy[i] = m_i[sigma_idx(row_i, 2*gi + 1)];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    b2s_g u_g (
      .a_i(ga[g]), .b_i(gb[g]), .c_i(gc[g]), .d_i(gd[g]),
      .x_i(gx[g]), .y_i(gy[g]),
      .a_o(oa[g]), .b_o(ob[g]), .c_o(oc[g]), .d_o(od[g])
    );
  end

  always_comb begin
    v_o = v_i;
    for (int i = 0; i < LANES; i++) begin
      v_o[ia[i]] = oa[i];
      v_o[ib[i]] = ob[i];
      v_o[ic[i]] = oc[i];
      v_o[id[i]] = od[i];
    end
  end
endmodule

// File: rtl/b2s_hdr_hash.sv
module b2s_hdr_hash
  import b2s_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [32*MSG_WORDS-1:0]   msg_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [32*DIG_WORDS-1:0]   digest_o
);
  localparam int NSTEP  = 2 * ROUNDS;
  localparam int STEP_W = $clog2(NSTEP);
  localparam word_t CNT_BLK0 = 32'd64;
  localparam word_t CNT_BLK1 = 32'd80;

  word_t msg_q [MSG_WORDS];
  word_t h_q [8], h_iv [8], h_fin [8], h_src [8];
  word_t v_q [16], v_nx [16], v_ld [16], m_sel [16];
  word_t dig_q [DIG_WORDS];
  logic [STEP_W-1:0] step_q;
  logic              blk_q, busy_q, done_q, last_step;
  logic [3:0]        row;

  assign last_step = (step_q == STEP_W'(NSTEP - 1));
  assign row       = 4'((int'(step_q) >> 1) % 10);

  always_comb begin
    for (int j = 0; j < 16; j++) begin
      if (blk_q) m_sel[j] = (j < 4) ? msg_q[16 + (j % 4)] : '0;
      else       m_sel[j] = msg_q[j];
    end
  end

  b2s_half u_half (
    .v_i(v_q), .m_i(m_sel), .row_i(row), .diag_i(step_q[0]), .v_o(v_nx)
  );

  // block-0 load when idle, block-1 load from the feed-forward when busy
  always_comb begin
    h_iv    = IV;
    h_iv[0] = IV[0] ^ PARAM_WORD;
    for (int i = 0; i < 8; i++) begin
      h_fin[i]   = h_q[i] ^ v_nx[i] ^ v_nx[i+8];
      h_src[i]   = busy_q ? h_fin[i] : h_iv[i];
      v_ld[i]    = h_src[i];
      v_ld[8+i]  = IV[i];
    end
    v_ld[12] = IV[4] ^ (busy_q ? CNT_BLK1 : CNT_BLK0);
    if (busy_q) v_ld[14] = ~IV[6];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MSG_WORDS; i++) msg_q[i] <= '0;
      for (int i = 0; i < 8; i++)         h_q[i]   <= '0;
      for (int i = 0; i < 16; i++)        v_q[i]   <= '0;
      for (int i = 0; i < DIG_WORDS; i++) dig_q[i] <= '0;
      step_q <= '0;
      blk_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          for (int i = 0; i < MSG_WORDS; i++) msg_q[i] <= msg_i[32*i +: 32];
          h_q    <= h_iv;
          v_q    <= v_ld;
          step_q <= '0;
          blk_q  <= 1'b0;
          busy_q <= 1'b1;
        end
      end else if (!last_step) begin
        v_q    <= v_nx;
        step_q <= step_q + 1'b1;
      end else if (!blk_q) begin
        h_q    <= h_fin;
        v_q    <= v_ld;
        step_q <= '0;
        blk_q  <= 1'b1;
      end else begin
        dig_q  <= h_fin;
        done_q <= 1'b1;
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  for (genvar k = 0; k < DIG_WORDS; k++) begin : g_dig
    assign digest_o[32*k +: 32] = dig_q[k];
  end
endmodule

// File: rtl/b2s_hdr_hash_chk.sv
module b2s_hdr_hash_chk #(
  parameter int ROUNDS = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [255:0] digest_o
);
  localparam int LAT = 4 * ROUNDS;
  int unsigned cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= 0;
    else if (!busy_o && start_i)  cnt_q <= 0;
    else if (busy_o)              cnt_q <= cnt_q + 1;
  end

  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt_q == LAT));
  a_r3_busy_falls_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r4_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  a_r5_digest_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(digest_o));
endmodule

bind b2s_hdr_hash b2s_hdr_hash_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .digest_o(digest_o)
);

// File: tb/sim_b2s_hdr_hash.sv
module sim_b2s_hdr_hash;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 40;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [639:0] msg_i = '0;
  logic         busy_o, done_o;
  logic [255:0] digest_o;

  int n_chk = 0, n_fail = 0;
  bit run_chk = 0, reported = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  b2s_hdr_hash u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .msg_i(msg_i),
    .busy_o(busy_o), .done_o(done_o), .digest_o(digest_o)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] iv_w(int i);
    logic [255:0] t = {32'h5BE0CD19, 32'h1F83D9AB, 32'h9B05688C, 32'h510E527F,
                       32'hA54FF53A, 32'h3C6EF372, 32'hBB67AE85, 32'h6A09E667};
    return t[32*i +: 32];
  endfunction

  function automatic int sg(int r, int k);
    logic [63:0] row;
    case (r)
      0: row = 64'h0123456789ABCDEF;  1: row = 64'hEA489FD61C02B753;
      2: row = 64'hB8C052FDAE367194;  3: row = 64'h7931DCBE265A40F8;
      4: row = 64'h905724AFE1BC683D;  5: row = 64'h2C6A0B834D75FE19;
      6: row = 64'hC51FED4A0763928B;  7: row = 64'hDB7EC13950F4862A;
      8: row = 64'h6FE9B308C2D714A5;  default: row = 64'hA2847615FB9E3CD0;
    endcase
    return int'(row[63 - 4*k -: 4]);
  endfunction

  function automatic logic [255:0] ref_compress(logic [255:0] h, logic [511:0] m,
                                                 int t, bit last);
    logic [31:0] v [16];
    logic [255:0] o;
    for (int i = 0; i < 8; i++) begin
      v[i] = h[32*i +: 32];
      v[i+8] = iv_w(i);
    end
    v[12] = v[12] ^ 32'(t);
    if (last) v[14] = ~v[14];
    for (int r = 0; r < 10; r++) begin
      for (int g = 0; g < 8; g++) begin
        int ln, a, b, c, d;
        logic [31:0] x, y;
        ln = g % 4;
        a = ln;
        b = (g < 4) ? 4 + ln  : 4 + (ln + 1) % 4;
        c = (g < 4) ? 8 + ln  : 8 + (ln + 2) % 4;
        d = (g < 4) ? 12 + ln : 12 + (ln + 3) % 4;
        x = m[32*sg(r, 2*g) +: 32];
        y = m[32*sg(r, 2*g+1) +: 32];
        v[a] = v[a] + v[b] + x;  v[d] = rr(v[d] ^ v[a], 16);
        v[c] = v[c] + v[d];      v[b] = rr(v[b] ^ v[c], 12);
        v[a] = v[a] + v[b] + y;  v[d] = rr(v[d] ^ v[a], 8);
        v[c] = v[c] + v[d];      v[b] = rr(v[b] ^ v[c], 7);
      end
    end
    for (int i = 0; i < 8; i++) o[32*i +: 32] = h[32*i +: 32] ^ v[i] ^ v[i+8];
    return o;
  endfunction

  function automatic logic [255:0] h_start();
    logic [255:0] h;
    for (int i = 0; i < 8; i++) h[32*i +: 32] = iv_w(i);
    h[31:0] = h[31:0] ^ 32'h0101_0020;
    return h;
  endfunction

  function automatic logic [255:0] ref_hash(logic [639:0] msg);
    logic [255:0] h;
    h = ref_compress(h_start(), msg[511:0], 64, 1'b0);
    return ref_compress(h, {384'b0, msg[639:512]}, 80, 1'b1);
  endfunction

  // cycle model
  bit           m_busy, m_done;
  int           m_cnt;
  logic [255:0] m_dig, m_pend;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_dig = '0; m_pend = '0;
    end else if (!m_busy) begin
      m_done = 0;
      if (start_i) begin
        m_busy = 1; m_cnt = 0; m_pend = ref_hash(msg_i);
      end
    end else begin
      m_cnt++;
      m_done = 0;
      if (m_cnt == LAT) begin
        m_busy = 0; m_done = 1; m_dig = m_pend;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (run_chk) begin
      chk(busy_o === m_busy, "R2 busy_o", 256'(busy_o), 256'(m_busy));
      chk(done_o === m_done, "R3 done_o", 256'(done_o), 256'(m_done));
      chk(digest_o === m_dig, "R5 digest_o", digest_o, m_dig);
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [639:0] rnd_msg();
    logic [639:0] m;
    for (int i = 0; i < 20; i++) m[32*i +: 32] = $urandom;
    return m;
  endfunction

  task automatic pulse_start(logic [639:0] m);
    @(posedge clk_i); #1;
    start_i = 1'b1; msg_i = m;
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < LAT + 10 && !seen; i++) begin
      @(negedge clk_i);
      if (done_o) seen = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [639:0] ma, mb;
    logic [255:0] kat;
    bit seen;

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #2;
    // R1: idle outputs after reset
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 flags", 256'({busy_o, done_o}), '0);
    chk(digest_o === '0, "R1 digest", digest_o, '0);
    run_chk = 1;

    // R8: model against the published digest of the empty message
    kat = {32'hf9eed01e, 32'hfd0d251b, 32'h1ea5a12c, 32'h48b6551f,
           32'h7c4a3542, 32'hd02111e1, 32'h94809079, 32'h307a2169};
    chk(ref_compress(h_start(), '0, 0, 1'b1) === kat, "R8 reference G/sigma",
        ref_compress(h_start(), '0, 0, 1'b1), kat);

    // R6/R7: all-zero message
    pulse_start('0);
    wait_done(seen);
    chk(seen && digest_o === ref_hash('0), "R6/R7 zero msg", digest_o, ref_hash('0));

    // R6: random messages
    for (int t = 0; t < 4; t++) begin
      ma = rnd_msg();
      pulse_start(ma);
      wait_done(seen);
      chk(seen && digest_o === ref_hash(ma), "R6 random msg", digest_o, ref_hash(ma));
    end

    // R4: start and message changes during a hash are ignored
    ma = rnd_msg();
    mb = rnd_msg();
    pulse_start(ma);
    repeat (5) @(posedge clk_i);
    #1 start_i = 1'b1; msg_i = mb;
    @(posedge clk_i); #1 start_i = 1'b0; msg_i = rnd_msg();
    wait_done(seen);
    chk(seen && digest_o === ref_hash(ma), "R4 busy start ignored", digest_o, ref_hash(ma));

    // R2/R3: start held high, restart accepted in the done cycle
    mb = rnd_msg();
    @(posedge clk_i); #1 start_i = 1'b1; msg_i = mb;
    wait_done(seen);
    @(negedge clk_i);
    chk(busy_o === 1'b1, "R2 restart in done cycle", 256'(busy_o), 256'(1));
    wait_done(seen);
    @(posedge clk_i); #1 start_i = 1'b0;
    chk(seen && digest_o === ref_hash(mb), "R3 back-to-back digest", digest_o, ref_hash(mb));
    repeat (LAT + 5) @(posedge clk_i);

    run_chk = 0;
    report();
  end
endmodule